// File: doc/BRIEF.md
# Receive Test-Pattern Compare Monitor

This block sits behind a character decoder on one receive lane. It checks the incoming character stream against a test pattern that it regenerates locally. It reports how the comparison is going on a 3-bit status code. When compare is enabled, the monitor first waits out a settling period. It then hunts for the zero data character that opens every pattern sequence. After that it compares each valid character against its own pattern copy. It keeps a running balance of errors against matches. If that balance climbs too high, it treats the lane as out of step and goes back to hunting.

A clock-recovery lock loss moves the monitor to the start state at once, from any state. An elasticity-buffer slip does the same. After a slip, the status stays in the start state until nine valid characters have arrived with no further slip. Each pattern sequence is 255 characters long. The monitor flags the last character of each sequence and then carries on directly into the next sequence.

The states are named as follows: OFF (000), START (001), HUNT (010), MATCH (011), MISS (100) and WRAP (101).
- OFF→START happens when compare is enabled.
- START→HUNT happens on the ninth valid character.
- HUNT→MATCH happens on the zero data character.
- MATCH/MISS/WRAP→MATCH or MISS happens on each compared character.
- MATCH/MISS→WRAP happens on the final character of a sequence.
- MATCH/MISS/WRAP→HUNT happens when the balance is lost.
- Any state→START happens on lock loss or a buffer slip.
- Any state→OFF happens when compare is disabled.

Top module: `rx_bist_monitor`

## Requirements
- R1: Out of reset, and on the clock after `cmp_en` is low, `bist_status` is 000. Disabling clears the hold count, the balance and the pattern position. Enabling again starts at START (001).
- R2: While `cmp_en` is high and `pll_locked` is low, the status moves to 001 on the next clock from any state and stays there. The settling count is held at zero for as long as lock is absent.
- R3: START (001) lasts until nine valid characters have been counted. The status shows 010 after the ninth. An `eb_fault` pulse forces 001 on the next clock and restarts the count of nine.
- R4: The state changes only on clocks with `chr_vld` high, except for the OFF exit, lock loss and buffer slips. Character inputs on clocks without `chr_vld` have no effect.
- R5: In HUNT (010), only a character with value 0x00 and `chr_is_data` = 1 moves the status to 011. Any other character, including a control 0x00, leaves it at 010.
- R6: The reference is an 8-bit register `s`, loaded with 0xFF when a sequence begins. Its next value is `{s[6:0], s[7]^s[5]^s[4]^s[3]}`, and the expected character is `s ^ 0xFF`. The zero data character that opens a sequence is position 0. Each later valid character advances `s` once.
- R7: A compared character matches only if `chr_is_data` = 1 and `chr_data` equals the expected value. A match gives status 011 and a mismatch gives 100.
- R8: The balance goes up by one on a mismatch and down by one on a match, and it never drops below zero. It is cleared when a sequence is acquired. A mismatch that would lift it above 16 sends the status to 010.
- R9: The character at position 254 shows 101 for one character time. The next valid character is compared as position 0 of a new sequence (expected 0x00), with the balance cleared first.
- R10: Priority from highest to lowest is: disable, then lock loss, then buffer slip, then the normal state flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare enable |
| pll_locked | input | 1 | Receive clock recovery in lock |
| eb_fault | input | 1 | Elasticity-buffer overflow/underflow pulse |
| chr_vld | input | 1 | Character valid strobe |
| chr_is_data | input | 1 | High for a data character, low for a control character |
| chr_data | input | 8 | Decoded character value |
| bist_status | output | 3 | Compare status code |

## Verification
The hardest state to reach is the WRAP code. It needs 254 consecutive characters that track the reference after an acquisition, with no slip or lock loss along the way. The bench keeps its own model of the reference register. It streams exactly that sequence and checks the status on every character. It then checks that the following zero character restarts the pattern. Balance loss is also a boundary case. To reach it, the bench first sends matches against an empty balance, so that a counter which failed to stop at zero would shift the trip point. It then counts exactly sixteen and seventeen mismatches.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'b000,
        ST_START = 3'b001,
        ST_HUNT  = 3'b010,
        ST_MATCH = 3'b011,
        ST_MISS  = 3'b100,
        ST_WRAP  = 3'b101
    } bist_state_t;

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
    parameter int          W       = 8,
    parameter int          SEQ_LEN = 255,
    parameter logic [W-1:0] SEED   = '1,
    parameter logic [W-1:0] TAPS   = 8'b1011_1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] expect_o,
    output logic         last_o
);
    localparam int IDX_W = $clog2(SEQ_LEN);

    logic [W-1:0]     reg_q, reg_base, reg_d;
    logic [IDX_W-1:0] idx_q, idx_base, idx_d;

    always_comb begin
        reg_base = load ? SEED : reg_q;
        idx_base = load ? '0 : idx_q;
        reg_d    = reg_base;
        idx_d    = idx_base;
        if (step) begin
            reg_d = {reg_base[W-2:0], ^(reg_base & TAPS)};
            idx_d = idx_base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= SEED;
            idx_q <= '0;
        end else begin
            reg_q <= reg_d;
            idx_q <= idx_d;
        end
    end

    assign expect_o = reg_q ^ SEED;
    assign last_o   = (idx_q == IDX_W'(SEQ_LEN - 1));
endmodule

// File: rtl/bist_balance.sv
module bist_balance #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic miss,
    output logic lost_o
);
    localparam int                 MAXV  = LIMIT + 1;
    localparam int                 BAL_W = $clog2(MAXV + 1);

    logic [BAL_W-1:0] bal_q, bal_base, bal_d;

    always_comb begin
        bal_base = clr ? '0 : bal_q;
        bal_d    = bal_base;
        if (step) begin
            if (miss) begin
                if (bal_base != BAL_W'(MAXV)) bal_d = bal_base + 1'b1;
            end else begin
                if (bal_base != '0) bal_d = bal_base - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bal_q <= '0;
        else        bal_q <= bal_d;
    end

    assign lost_o = step && (bal_d > BAL_W'(LIMIT));
endmodule

// File: rtl/bist_hold_timer.sv
module bist_hold_timer #(
    parameter int HOLD = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire_o
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = tick && !clr && (cnt_q == CNT_W'(HOLD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (expire_o) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rx_bist_monitor.sv
module rx_bist_monitor
    import rx_bist_pkg::*;
#(
    parameter int CHR_W      = 8,
    parameter int SEQ_LEN    = 255,
    parameter int LOSS_LIMIT = 16,
    parameter int HOLD_CHARS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic             pll_locked,
    input  logic             eb_fault,
    input  logic             chr_vld,
    input  logic             chr_is_data,
    input  logic [CHR_W-1:0] chr_data,
    output logic [2:0]       bist_status
);
    bist_state_t state_q, state_d;

    logic             pat_load, pat_step, pat_last;
    logic [CHR_W-1:0] pat_expect;
    logic             bal_clr, bal_step, bal_lost;
    logic             hold_clr, hold_expire;
    logic             chr_match, chr_is_open;

    assign chr_match   = chr_is_data && (chr_data == pat_expect);
    assign chr_is_open = chr_is_data && (chr_data == '0);

    bist_pattern_gen #(
        .W       (CHR_W),
        .SEQ_LEN (SEQ_LEN),
        .SEED    ({CHR_W{1'b1}}),
        .TAPS    (CHR_W'(8'b1011_1000))
    ) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pat_load),
        .step     (pat_step),
        .expect_o (pat_expect),
        .last_o   (pat_last)
    );

    bist_balance #(
        .LIMIT (LOSS_LIMIT)
    ) u_balance (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (bal_clr),
        .step   (bal_step),
        .miss   (!chr_match),
        .lost_o (bal_lost)
    );

    bist_hold_timer #(
        .HOLD (HOLD_CHARS)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold_clr),
        .tick     (chr_vld),
        .expire_o (hold_expire)
    );

    // next-state and control
    always_comb begin
        state_d  = state_q;
        pat_load = 1'b0;
        pat_step = 1'b0;
        bal_clr  = 1'b0;
        bal_step = 1'b0;
        hold_clr = (state_q != ST_START);
        if (!cmp_en) begin
            state_d  = ST_OFF;
            pat_load = 1'b1;
            bal_clr  = 1'b1;
            hold_clr = 1'b1;
        end else if (!pll_locked || eb_fault) begin
            state_d  = ST_START;
            pat_load = 1'b1;
            bal_clr  = 1'b1;
            hold_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d  = ST_START;
                    pat_load = 1'b1;
                    bal_clr  = 1'b1;
                end
                ST_START: begin
                    pat_load = 1'b1;
                    bal_clr  = 1'b1;
                    if (hold_expire) state_d = ST_HUNT;
                end
                ST_HUNT: begin
                    pat_load = 1'b1;
                    bal_clr  = 1'b1;
                    if (chr_vld && chr_is_open) begin
                        pat_step = 1'b1;
                        state_d  = ST_MATCH;
                    end
                end
                ST_MATCH, ST_MISS, ST_WRAP: begin
                    if (chr_vld) begin
                        bal_step = 1'b1;
                        bal_clr  = (state_q == ST_WRAP);
                        if (bal_lost) begin
                            state_d  = ST_HUNT;
                            pat_load = 1'b1;
                        end else if (pat_last) begin
                            state_d  = ST_WRAP;
                            pat_load = 1'b1;
                        end else begin
                            pat_step = 1'b1;
                            state_d  = chr_match ? ST_MATCH : ST_MISS;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        bist_status = state_q;
    end
endmodule

// File: rtl/rx_bist_monitor_chk.sv
module rx_bist_monitor_chk #(
    parameter int CHR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_en,
    input logic             pll_locked,
    input logic             eb_fault,
    input logic             chr_vld,
    input logic             chr_is_data,
    input logic [CHR_W-1:0] chr_data,
    input logic [2:0]       bist_status
);
    logic run_ok;
    assign run_ok = cmp_en && pll_locked && !eb_fault;

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> bist_status == 3'b000);

    a_r2_lock_loss_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && !pll_locked |=> bist_status == 3'b001);

    a_r3_slip_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en && pll_locked && eb_fault |=> bist_status == 3'b001);

    a_r4_idle_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && !chr_vld && bist_status != 3'b000 |=> $stable(bist_status));

    a_r5_hunt_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && chr_vld && bist_status == 3'b010 &&
        !(chr_is_data && chr_data == '0) |=> bist_status == 3'b010);

    a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        bist_status <= 3'b101);

    a_r9_wrap_one_char: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && chr_vld && bist_status == 3'b101 |=>
        (bist_status == 3'b011 || bist_status == 3'b100));
endmodule

bind rx_bist_monitor rx_bist_monitor_chk #(.CHR_W(CHR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_en      (cmp_en),
    .pll_locked  (pll_locked),
    .eb_fault    (eb_fault),
    .chr_vld     (chr_vld),
    .chr_is_data (chr_is_data),
    .chr_data    (chr_data),
    .bist_status (bist_status)
);

// File: tb/rx_bist_monitor_bench.sv
`timescale 1ns/1ps
module rx_bist_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_en = 1'b0, pll_locked = 1'b0, eb_fault = 1'b0;
    logic       chr_vld = 1'b0, chr_is_data = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic [2:0] bist_status;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_s;
    int         ref_pos;

    always #2 clk = ~clk;

    rx_bist_monitor u_rx_bist_monitor (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .pll_locked(pll_locked),
        .eb_fault(eb_fault), .chr_vld(chr_vld), .chr_is_data(chr_is_data),
        .chr_data(chr_data), .bist_status(bist_status)
    );

    function automatic logic [7:0] ref_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        checks++;
        if (bist_status !== exp) begin
            errors++;
            $display("FAIL %s: status got %b expected %b at %0t", req, bist_status, exp, $time);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic isd);
        chr_vld = 1'b1; chr_data = d; chr_is_data = isd;
        @(negedge clk);
        chr_vld = 1'b0;
    endtask

    task automatic send_good();
        send(ref_s ^ 8'hFF, 1'b1);
        ref_s = ref_next(ref_s);
        ref_pos++;
    endtask

    task automatic send_bad();
        send((ref_s ^ 8'hFF) ^ 8'h5A, 1'b1);
        ref_s = ref_next(ref_s);
        ref_pos++;
    endtask

    task automatic wait_settle(input string req);
        for (int i = 0; i < 8; i++) send(8'hC3, 1'b1);
        check(req, 3'b001);
        send(8'hC3, 1'b1);
        check(req, 3'b010);
    endtask

    task automatic acquire();
        send(8'h00, 1'b1);
        check("R5 acquire", 3'b011);
        ref_s = ref_next(8'hFF);
        ref_pos = 1;
    endtask

    task automatic t_reset();
        check("R1 reset", 3'b000);
    endtask

    task automatic t_enable();
        cmp_en = 1'b1;
        @(negedge clk);
        check("R3 enable to start", 3'b001);
        wait_settle("R3 nine char hold");
    endtask

    task automatic t_hunt();
        send(8'h55, 1'b1);
        check("R5 hunt other data", 3'b010);
        send(8'h00, 1'b0);
        check("R5 hunt control zero", 3'b010);
        acquire();
    endtask

    task automatic t_compare();
        send_good();
        check("R7 match", 3'b011);
        send_bad();
        check("R7 mismatch", 3'b100);
        send_good();
        check("R6 pattern after miss", 3'b011);
    endtask

    task automatic t_gate();
        chr_data = 8'hA5; chr_is_data = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 no strobe", 3'b011);
        send_good();
        check("R4 pattern not advanced", 3'b011);
    endtask

    task automatic t_wrap();
        while (ref_pos < 254) begin
            send_good();
            check("R6 sequence", 3'b011);
        end
        send_good();
        check("R9 wrap code", 3'b101);
        send(8'h5A, 1'b1);
        check("R9 restart mismatch", 3'b100);
        ref_s = ref_next(8'hFF);
        ref_pos = 1;
        send_good();
        check("R9 restart pattern", 3'b011);
    endtask

    task automatic t_balance();
        for (int i = 0; i < 4; i++) send_good();
        check("R8 floor", 3'b011);
        send(ref_s ^ 8'hFF, 1'b0);
        ref_s = ref_next(ref_s);
        ref_pos++;
        check("R7 control flag mismatch", 3'b100);
        for (int i = 0; i < 15; i++) send_bad();
        check("R8 sixteen misses", 3'b100);
        send_bad();
        check("R8 seventeen misses", 3'b010);
        acquire();
        send_bad(); send_good(); send_bad();
        check("R8 up and down", 3'b100);
    endtask

    task automatic t_lock();
        pll_locked = 1'b0;
        @(negedge clk);
        check("R2 lock loss", 3'b001);
        for (int i = 0; i < 5; i++) send(8'h11, 1'b1);
        check("R2 stays while unlocked", 3'b001);
        pll_locked = 1'b1;
        wait_settle("R2 count restarts after lock");
        acquire();
    endtask

    task automatic t_fault();
        eb_fault = 1'b1;
        @(negedge clk);
        eb_fault = 1'b0;
        check("R3 slip", 3'b001);
        for (int i = 0; i < 5; i++) send(8'h22, 1'b1);
        eb_fault = 1'b1;
        @(negedge clk);
        eb_fault = 1'b0;
        check("R3 second slip", 3'b001);
        wait_settle("R3 hold restarted");
        acquire();
    endtask

    task automatic t_priority();
        cmp_en = 1'b0; pll_locked = 1'b0; eb_fault = 1'b1;
        @(negedge clk);
        check("R10 disable wins", 3'b000);
        cmp_en = 1'b1;
        @(negedge clk);
        check("R10 lock over slip", 3'b001);
        pll_locked = 1'b1; eb_fault = 1'b0;
        @(negedge clk);
        wait_settle("R1 re-enable clears");
        acquire();
        cmp_en = 1'b0;
        @(negedge clk);
        check("R1 disable", 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pll_locked = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_hunt();
        t_compare();
        t_gate();
        t_wrap();
        t_balance();
        t_lock();
        t_fault();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule